// File: doc/BRIEF.md
# Frame Timestamp Counter

This block keeps a 16-bit free-running time reference for a CAN controller and stamps finished frames with it. It counts a prescaled version of the controller's bit-clock tick. Software chooses a division ratio from one to four. When a frame finishes, the block emits a one-cycle capture strobe. The strobe carries the index of the message slot that handled the frame, its frame-type flag and the count value. The slot storage writes these into the slot.

A two-bit module-reset field controls the counter. With both bits low, the counter runs. With both bits high, it is forced to zero. The two mixed codes freeze the counter at its current value. A one-cycle software strobe also zeroes the count. Any clear restarts the prescaler, so after a clear the first increment always comes a full division period later.

In loopback operation, transmit completions are never stamped. Receive completions are stamped only when the receiving slot reports that it can accept the message. In normal operation, every completion is stamped and the slot-available flag has no effect.

Top module: `tstamp_unit`

## Requirements
- R1: While the active-low reset is asserted, `count` reads 0000h and `capValid` reads 0.
- R2: While running, `count` advances by one for every N sampled cycles with `bitTick` high, where N = `preSel` + 1 (code 00 divides by 1, 01 by 2, 10 by 3, 11 by 4).
- R3: With `modRst` equal to 01 or 10 and no software clear, `count` keeps its value whatever `bitTick` does.
- R4: With `modRst` equal to 11, `count` becomes 0000h at the next clock edge and stays there.
- R5: A `swClear` pulse makes `count` 0000h at the next edge and restarts the prescaler, so the first increment afterwards needs a full N ticks.
- R6: A count event while `count` holds FFFFh makes it 0000h.
- R7: When a clear and a count event fall in the same cycle, `count` becomes 0000h. A capture in that cycle reports the value held before the update.
- R8: With `loopMode` low, a `txDone` or `rxDone` pulse produces `capValid` one cycle later. The strobe carries `doneSlot`, `remoteFrame` and the value `count` held in the pulse cycle. `slotAvail` has no effect in this mode.
- R9: With `loopMode` high, `txDone` never produces a capture. `rxDone` produces one only when `slotAvail` is 1.
- R10: When `txDone` and `rxDone` arrive in the same cycle, exactly one capture results. That capture follows the receive rule and reports the shared `doneSlot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle pulse per CAN bit-clock period |
| preSel | input | 2 | Prescale code: divide by preSel+1 |
| modRst | input | 2 | Module-reset field: 00 run, 11 clear, 01/10 hold |
| swClear | input | 1 | One-cycle software clear strobe |
| loopMode | input | 1 | Loopback operation flag |
| txDone | input | 1 | Transmit completion pulse |
| rxDone | input | 1 | Receive completion pulse |
| doneSlot | input | 5 | Slot index of the completed frame |
| remoteFrame | input | 1 | Frame-type flag of the completed frame (1 = remote) |
| slotAvail | input | 1 | Receiving slot can accept the message |
| count | output | 16 | Live timestamp value |
| capValid | output | 1 | Capture strobe |
| capSlot | output | 5 | Slot index for the capture |
| capRemote | output | 1 | Frame-type flag for the capture |
| capValue | output | 16 | Captured timestamp |

## Verification
Every result is due exactly one clock edge after the cycle in which its stimulus is sampled. A tick, clear or mode change shows on `count` after that edge. A completion pulse shows on `capValid` and the capture fields after that edge. The bench drives inputs on falling edges. Its driver pushes each expected capture into a queue at the rising edge that samples the pulse. The monitor pops the queue on the following falling edge, so a late, early, missing or extra capture is caught. Count checks are likewise taken on falling edges once the last stimulus edge has passed.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int CNT_W_DEF  = 16;
  localparam int SLOT_W_DEF = 5;
  localparam int PRE_W      = 2;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic countEn;  // prescaled count event
    logic clear;    // zero the counter (wins over countEn)
    logic capture;  // latch count and slot info
  } stampCtl_t;
endpackage

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic [PRE_W-1:0] preSel,
  input  logic [1:0]       modRst,
  input  logic             swClear,
  input  logic             loopMode,
  input  logic             txDone,
  input  logic             rxDone,
  input  logic             slotAvail,
  output stampCtl_t        ctl
);
  logic             running;
  logic             hardClear;
  logic             anyClear;
  logic [PRE_W-1:0] divCnt;
  logic             divHit;

  assign running   = (modRst == 2'b00);
  assign hardClear = (modRst == 2'b11);
  assign anyClear  = hardClear | swClear;
  assign divHit    = running & bitTick & (divCnt >= preSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (anyClear) begin
      divCnt <= '0;
    end else if (running && bitTick) begin
      if (divHit) divCnt <= '0;
      else        divCnt <= divCnt + 1'b1;
    end
  end

  logic rxTake;
  logic txTake;
  assign rxTake = rxDone & (~loopMode | slotAvail);
  assign txTake = txDone & ~loopMode;

  always_comb begin
    ctl.countEn = divHit;
    ctl.clear   = anyClear;
    // receive rule governs when both completions coincide
    ctl.capture = rxDone ? rxTake : txTake;
  end

  AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !ctl.clear && preSel != '0 && $stable(preSel)) |=> !ctl.countEn); // R2
  AST_LOOP_TX_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (loopMode && txDone && !rxDone) |-> !ctl.capture); // R9
  AST_LOOP_NEED_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (loopMode && rxDone && !slotAvail) |-> !ctl.capture); // R9
  AST_STOPPED_NO_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (modRst == 2'b01 || modRst == 2'b10) |-> !ctl.countEn); // R3
endmodule

// File: rtl/tstamp_datapath.sv
module tstamp_datapath
  import tstamp_pkg::*;
#(
  parameter int CNT_W  = CNT_W_DEF,
  parameter int SLOT_W = SLOT_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  stampCtl_t         ctl,
  input  logic [SLOT_W-1:0] doneSlot,
  input  logic              remoteFrame,
  output logic [CNT_W-1:0]  count,
  output logic              capValid,
  output logic [SLOT_W-1:0] capSlot,
  output logic              capRemote,
  output logic [CNT_W-1:0]  capValue
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (ctl.clear) begin
      count <= '0;
    end else if (ctl.countEn) begin
      count <= count + 1'b1; // natural wrap from all ones
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid  <= 1'b0;
      capSlot   <= '0;
      capRemote <= 1'b0;
      capValue  <= '0;
    end else begin
      capValid <= ctl.capture;
      if (ctl.capture) begin
        capSlot   <= doneSlot;
        capRemote <= remoteFrame;
        capValue  <= count;
      end
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (count == '0)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && !ctl.clear) |=> (count == $past(count) + 1'b1)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.countEn && !ctl.clear) |=> $stable(count)); // R3
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (capValid && capValue == $past(count) && capSlot == $past(doneSlot))); // R8
  AST_NO_STRAY_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> !capValid); // R9
endmodule

// File: rtl/tstamp_unit.sv
module tstamp_unit
  import tstamp_pkg::*;
#(
  parameter int CNT_W  = CNT_W_DEF,
  parameter int SLOT_W = SLOT_W_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic [1:0]        preSel,
  input  logic [1:0]        modRst,
  input  logic              swClear,
  input  logic              loopMode,
  input  logic              txDone,
  input  logic              rxDone,
  input  logic [SLOT_W-1:0] doneSlot,
  input  logic              remoteFrame,
  input  logic              slotAvail,
  output logic [CNT_W-1:0]  count,
  output logic              capValid,
  output logic [SLOT_W-1:0] capSlot,
  output logic              capRemote,
  output logic [CNT_W-1:0]  capValue
);
  stampCtl_t ctl;

  tstamp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitTick   (bitTick),
    .preSel    (preSel),
    .modRst    (modRst),
    .swClear   (swClear),
    .loopMode  (loopMode),
    .txDone    (txDone),
    .rxDone    (rxDone),
    .slotAvail (slotAvail),
    .ctl       (ctl)
  );

  tstamp_datapath #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .doneSlot    (doneSlot),
    .remoteFrame (remoteFrame),
    .count       (count),
    .capValid    (capValid),
    .capSlot     (capSlot),
    .capRemote   (capRemote),
    .capValue    (capValue)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |-> (count == '0 && !capValid)); // R1
  AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (modRst == 2'b11) |=> (count == '0)); // R4
  AST_CLEAR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (swClear && bitTick) |=> (count == '0)); // R7
endmodule

// File: tb/tstamp_unit_tb.sv
module tstamp_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bitTick = 1'b0;
  logic [1:0]    preSel = 2'b00;
  logic [1:0]    modRst = 2'b11;
  logic          swClear = 1'b0;
  logic          loopMode = 1'b0;
  logic          txDone = 1'b0;
  logic          rxDone = 1'b0;
  logic [SW-1:0] doneSlot = '0;
  logic          remoteFrame = 1'b0;
  logic          slotAvail = 1'b0;
  logic [15:0]   count;
  logic          capValid;
  logic [SW-1:0] capSlot;
  logic          capRemote;
  logic [15:0]   capValue;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [SW-1:0] slot;
    logic          remote;
    logic [15:0]   value;
    string         tag;
  } capItem_t;
  capItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tstamp_unit u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .preSel(preSel), .modRst(modRst),
    .swClear(swClear), .loopMode(loopMode), .txDone(txDone), .rxDone(rxDone),
    .doneSlot(doneSlot), .remoteFrame(remoteFrame), .slotAvail(slotAvail),
    .count(count), .capValid(capValid), .capSlot(capSlot), .capRemote(capRemote),
    .capValue(capValue)
  );

  task automatic checkCount(input logic [15:0] exp, input string tag);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s: count actual %h expected %h", tag, count, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a capture appears
  always @(negedge clk) begin
    if (rstN) begin
      if (capValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R9: unexpected capture actual slot %0d value %h expected none", capSlot, capValue);
        end else begin
          capItem_t it;
          it = expQ.pop_front();
          if (capSlot !== it.slot || capRemote !== it.remote || capValue !== it.value) begin
            errors++;
            $display("FAIL %s: capture actual slot %0d remote %0b value %h expected slot %0d remote %0b value %h",
                     it.tag, capSlot, capRemote, capValue, it.slot, it.remote, it.value);
          end
        end
      end else if (expQ.size() != 0) begin
        capItem_t it;
        it = expQ.pop_front();
        checks++;
        errors++;
        $display("FAIL %s: capture actual none expected slot %0d value %h", it.tag, it.slot, it.value);
      end
    end
  end

  task automatic runTicks(input int n);
    bitTick = 1'b1;
    repeat (n) @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic pulseClear();
    swClear = 1'b1;
    @(negedge clk);
    swClear = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    modRst = m;
    @(negedge clk);
  endtask

  // driver: applies one completion cycle and queues the expected capture
  task automatic doStrobe(input logic tx, input logic rx, input logic [SW-1:0] slot,
                          input logic remote, input logic avail, input logic clr,
                          input logic tick, input logic expCap,
                          input logic [15:0] expVal, input string tag);
    txDone = tx; rxDone = rx; doneSlot = slot; remoteFrame = remote;
    slotAvail = avail; swClear = clr; bitTick = tick;
    @(posedge clk);
    if (expCap) begin
      capItem_t it;
      it.slot = slot; it.remote = remote; it.value = expVal; it.tag = tag;
      expQ.push_back(it);
    end
    @(negedge clk);
    txDone = 0; rxDone = 0; swClear = 0; bitTick = 0; slotAvail = 0;
    if (!expCap) begin
      checks++;
      if (capValid !== 1'b0) begin
        errors++;
        $display("FAIL %s: capValid actual %0b expected 0", tag, capValid);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (count !== 16'h0 || capValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset count %h capValid %0b expected 0000 0", count, capValid);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R4: held at 11, ticks do nothing
    runTicks(5);
    checkCount(16'h0, "R4 held clear");
    setMode(2'b00);

    // R2: divide by 1
    runTicks(10);
    checkCount(16'd10, "R2 code00");
    // R2 / R5: other codes from a fresh clear
    for (int c = 1; c < 4; c++) begin
      preSel = c[1:0];
      pulseClear();
      checkCount(16'h0, "R5 clear");
      runTicks(4 * (c + 1) + c);
      checkCount(16'd4, $sformatf("R2 code%0d", c));
    end

    // R5: prescaler restarts after clear
    preSel = 2'd3;
    pulseClear();
    runTicks(6);
    checkCount(16'd1, "R5 partial");
    pulseClear();
    runTicks(3);
    checkCount(16'd0, "R5 restart short");
    runTicks(1);
    checkCount(16'd1, "R5 restart full");

    // R3: mixed codes freeze
    setMode(2'b01);
    runTicks(8);
    checkCount(16'd1, "R3 code01");
    setMode(2'b10);
    runTicks(8);
    checkCount(16'd1, "R3 code10");
    setMode(2'b00);

    // R4: code 11 zeroes
    preSel = 2'd0;
    runTicks(5);
    checkCount(16'd6, "R4 before");
    setMode(2'b11);
    checkCount(16'd0, "R4 clear");
    setMode(2'b00);

    // R8: normal-mode captures
    runTicks(7);
    doStrobe(1, 0, 5'd3, 0, 0, 0, 0, 1, 16'd7, "R8 tx");
    doStrobe(0, 1, 5'd12, 1, 0, 0, 0, 1, 16'd7, "R8 rx no avail");
    doStrobe(0, 1, 5'd5, 0, 1, 0, 1, 1, 16'd7, "R8 rx with tick");
    checkCount(16'd8, "R8 count after tick");

    // R9: loopback rules
    loopMode = 1'b1;
    doStrobe(1, 0, 5'd2, 0, 1, 0, 0, 0, 16'd0, "R9 tx");
    doStrobe(0, 1, 5'd9, 0, 0, 0, 0, 0, 16'd0, "R9 rx unavailable");
    doStrobe(0, 1, 5'd9, 1, 1, 0, 0, 1, 16'd8, "R9 rx available");
    doStrobe(1, 1, 5'd17, 0, 0, 0, 0, 0, 16'd0, "R10 loop both no slot");
    loopMode = 1'b0;

    // R10: both completions in normal mode
    doStrobe(1, 1, 5'd20, 1, 0, 0, 0, 1, 16'd8, "R10 both");

    // R7: clear and count event together, capture sees old value
    runTicks(4);
    checkCount(16'd12, "R7 before");
    doStrobe(0, 1, 5'd1, 0, 0, 1, 1, 1, 16'd12, "R7 capture");
    checkCount(16'd0, "R7 clear wins");

    // R6: wrap
    runTicks(65535);
    checkCount(16'hFFFF, "R6 full");
    runTicks(1);
    checkCount(16'h0000, "R6 wrap");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule